// File: doc/BRIEF.md
# Digital Potentiometer Register Map

This block is the register file that sits behind a two-wire serial slave engine in a 256-step digitally controlled potentiometer. The engine decodes the bus. This block sees only byte-level events: a memory-address byte, a write-data byte, a request for the next read byte, START, STOP and each SCL rising edge. For each incoming byte it decides whether to acknowledge it. It returns read bytes, drives the 8-bit wiper code to the resistor ladder, and raises a busy flag that the engine uses to refuse its own slave address.

Storage has two kinds.

- **Volatile:** the wiper code and a one-bit access-control flag.
- **Non-volatile (held in flops):** an initial-value byte and five general-purpose bytes.

Location 0 is shared between the two kinds. The access-control flag selects which one a read or write reaches.

A non-volatile write is only staged when its data byte arrives. It is committed when STOP is the very next bus event, and a programming timer then holds the part busy. After reset, the wiper sits at mid-scale until a short recall sequence copies the stored initial value into it. A write-protect input makes all non-volatile locations read-only.

The engine pulses `wdat_vld` once the acknowledge slot of a data byte has ended. Any SCL rising edge after that pulse therefore belongs to further traffic.

Top module: `dpot_regmap`

## Requirements
- R1: While `rst` is high, the wiper is 80h and `busy` is high. After `rst` falls, `busy` stays high for exactly RECALL_CYC cycles. At the clock edge where `busy` falls, the wiper takes the stored initial value. The control flag resets to 0. The stored bytes survive `rst`.
- R2: When idle, an address byte of 07h or any value above 08h gets a NACK and leaves the pointer unchanged. The values 00h–06h and 08h get an ACK and load the pointer.
- R3: A data byte at location 08h loads its bit 7 into the control flag. It is ACKed only when the byte is 00h or 80h and NACKed for any other value. A read of 08h returns the flag in bit 7 with bits 6–0 zero.
- R4: With the flag at 0, an accepted write to location 0 sets the wiper at once and stages the same byte for the initial-value register, and a read of 0 returns the stored initial value. With the flag at 1, a write to 0 changes only the wiper and starts no programming, and a read of 0 returns the wiper.
- R5: Location 01h reads D0h. A write to it is ACKed and changes nothing.
- R6: Locations 02h–06h read 00h and the initial value reads 80h until they are first programmed.
- R7: A staged non-volatile byte is written only if STOP is the next event after its data byte. An SCL rise, a START, an address byte, another data byte or a read request first discards it, and the stored value stays the same.
- R8: A commit holds `busy` high for exactly PROG_CYC cycles, from the cycle after STOP. While `busy` is high, address and data bytes get a NACK and change no state, including the wiper.
- R9: After the address byte, a second or later data byte in the same transfer is accepted only if the transfer began at 08h and no non-volatile byte has yet been staged in it. Otherwise it is NACKed and discards any staged byte. The pointer steps from 08h to 00h.
- R10: While `wp_n` is low, data bytes aimed at non-volatile storage are NACKed and change nothing, including the wiper. These are 02h–06h, and 0 when the flag is 0. A STOP that arrives with `wp_n` low starts no commit. Taking `wp_n` low after a commit has started neither shortens `busy` nor blocks the write.
- R11: Every read request returns the byte at the pointer and advances the pointer, wrapping from 08h to 00h. Location 07h, reachable only this way, reads FFh. A read with no new address byte continues from where the pointer was left.
- R12: `ack` and `rd_data` are registered. They change in the cycle after the event that produces them and hold their value until the next such event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, treated as power-up |
| wp_n | input | 1 | Write protect, active low |
| ev_start | input | 1 | START or repeated START seen (one-cycle pulse) |
| ev_stop | input | 1 | STOP seen (one-cycle pulse) |
| scl_rise | input | 1 | SCL rising edge seen (one-cycle pulse) |
| addr_vld | input | 1 | Memory-address byte received in `rx_byte` |
| wdat_vld | input | 1 | Write-data byte received in `rx_byte`, acknowledge slot complete |
| rd_req | input | 1 | Next read byte requested |
| rx_byte | input | 8 | Received byte |
| ack | output | 1 | 1 = acknowledge, 0 = no acknowledge, for the last byte |
| rd_data | output | 8 | Byte to shift out for the last read request |
| wiper | output | 8 | Tap select code for the resistor ladder |
| busy | output | 1 | Recall or non-volatile programming in progress |

## Verification
A wrong pointer or a wrong control flag shows on `rd_data` in the cycle after the next read request, and on `ack` after the next data byte. A staged byte that is kept or dropped wrongly shows on `busy` in the cycle after STOP, and later as a stale value on a read-back. A mistake in either timer shows as `busy` falling one cycle early or late, or, in the recall timer, as the wiper loading at the wrong edge. Because the reference model is compared on every clock, each of these faults is caught within one cycle of the first port where it becomes visible.

// File: rtl/dpot_regmap_pkg.sv
package dpot_regmap_pkg;
  localparam int DW       = 8;
  localparam int AW       = 4;
  localparam int NV_DEPTH = 7;

  localparam logic [AW-1:0] LOC_SHARED  = 4'd0;
  localparam logic [AW-1:0] LOC_IDENT   = 4'd1;
  localparam logic [AW-1:0] LOC_GP_LO   = 4'd2;
  localparam logic [AW-1:0] LOC_GP_HI   = 4'd6;
  localparam logic [AW-1:0] LOC_HOLE    = 4'd7;
  localparam logic [AW-1:0] LOC_CTRL    = 4'd8;

  localparam logic [DW-1:0] IDENT_CODE  = 8'hD0;
  localparam logic [DW-1:0] MID_CODE    = 8'h80;
  localparam logic [DW-1:0] HOLE_CODE   = 8'hFF;
  localparam logic [DW-1:0] GP_DEFAULT  = 8'h00;

  typedef struct packed {
    logic accept;
    logic to_nv;
    logic to_wiper;
    logic to_ctrl;
  } wr_dec_t;
endpackage

// File: rtl/dpot_recall.sv
module dpot_recall #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst,
  output logic active,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  assign done = active && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= CW'(CYC);
      active <= 1'b1;
    end else if (active) begin
      cnt <= cnt - 1'b1;
      if (done) active <= 1'b0;
    end
  end
endmodule

// File: rtl/dpot_nv_bank.sv
module dpot_nv_bank #(
  parameter int DW       = 8,
  parameter int DEPTH    = 7,
  parameter int PROG_CYC = 1250000,
  localparam int IW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] ivr,
  output logic          busy
);
  localparam int CW = $clog2(PROG_CYC + 1);

  logic [DW-1:0] cells [DEPTH];
  logic [CW-1:0] cnt;

  // Factory contents; the cells have no reset so they survive rst.
  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = (i == 0) ? 8'h80 : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (commit) cells[wr_idx] <= wr_data;
  end

  assign rd_data = cells[rd_idx];
  assign ivr     = cells[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (commit) begin
      cnt  <= CW'(PROG_CYC);
      busy <= 1'b1;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/dpot_regmap.sv
module dpot_regmap
  import dpot_regmap_pkg::*;
#(
  parameter int PROG_CYC   = 1250000,
  parameter int RECALL_CYC = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wp_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       scl_rise,
  input  logic       addr_vld,
  input  logic       wdat_vld,
  input  logic       rd_req,
  input  logic [7:0] rx_byte,
  output logic       ack,
  output logic [7:0] rd_data,
  output logic [7:0] wiper,
  output logic       busy
);
  localparam int IW = $clog2(NV_DEPTH);

  logic          rcl_active, rcl_done, nv_busy, busy_all, commit;
  logic [DW-1:0] nv_rd, nv_ivr;
  logic [AW-1:0] ptr_q, ptr_nx;
  logic          vol_q, open_q, b8_q, pend_q, ack_q;
  logic [IW-1:0] pend_idx;
  logic [DW-1:0] pend_dat, wiper_q, rd_q, rd_mux;
  logic          addr_bad, any_evt, in_gp;
  wr_dec_t       dec;

  dpot_recall #(.CYC(RECALL_CYC)) u_rcl (
    .clk    (clk),
    .rst    (rst),
    .active (rcl_active),
    .done   (rcl_done)
  );

  dpot_nv_bank #(.DW(DW), .DEPTH(NV_DEPTH), .PROG_CYC(PROG_CYC)) u_nv (
    .clk     (clk),
    .rst     (rst),
    .commit  (commit),
    .wr_idx  (pend_idx),
    .wr_data (pend_dat),
    .rd_idx  (ptr_q[IW-1:0]),
    .rd_data (nv_rd),
    .ivr     (nv_ivr),
    .busy    (nv_busy)
  );

  assign busy_all = rcl_active | nv_busy;
  assign commit   = ev_stop & pend_q & wp_n & ~nv_busy;
  assign ptr_nx   = (ptr_q == LOC_CTRL) ? '0 : ptr_q + 1'b1;
  assign addr_bad = (rx_byte == DW'(LOC_HOLE)) || (rx_byte > DW'(LOC_CTRL));
  assign any_evt  = ev_start | ev_stop | scl_rise | addr_vld | wdat_vld | rd_req;
  assign in_gp    = (ptr_q >= LOC_GP_LO) && (ptr_q <= LOC_GP_HI);

  // Decide what a data byte at the current pointer does.
  always_comb begin
    dec = '0;
    if (ptr_q == LOC_SHARED) begin
      dec.accept   = vol_q | wp_n;
      dec.to_wiper = vol_q | wp_n;
      dec.to_nv    = ~vol_q & wp_n;
    end else if (ptr_q == LOC_IDENT) begin
      dec.accept = 1'b1;
    end else if (in_gp) begin
      dec.accept = wp_n;
      dec.to_nv  = wp_n;
    end else if (ptr_q == LOC_CTRL) begin
      dec.to_ctrl = 1'b1;
      dec.accept  = (rx_byte == 8'h00) || (rx_byte == MID_CODE);
    end
  end

  // Byte returned for a read at the current pointer.
  always_comb begin
    if (ptr_q == LOC_SHARED)     rd_mux = vol_q ? wiper_q : nv_ivr;
    else if (ptr_q == LOC_IDENT) rd_mux = IDENT_CODE;
    else if (in_gp)              rd_mux = nv_rd;
    else if (ptr_q == LOC_CTRL)  rd_mux = {vol_q, 7'b0};
    else                         rd_mux = HOLE_CODE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wiper_q  <= MID_CODE;
      vol_q    <= 1'b0;
      ptr_q    <= '0;
      open_q   <= 1'b0;
      b8_q     <= 1'b0;
      pend_q   <= 1'b0;
      pend_idx <= '0;
      pend_dat <= '0;
      ack_q    <= 1'b0;
      rd_q     <= '0;
    end else begin
      if (rcl_done) wiper_q <= nv_ivr;
      if (any_evt) pend_q <= 1'b0;
      if (ev_start | ev_stop) open_q <= 1'b0;

      if (addr_vld) begin
        if (busy_all || addr_bad) begin
          ack_q  <= 1'b0;
          open_q <= 1'b0;
        end else begin
          ack_q  <= 1'b1;
          ptr_q  <= rx_byte[AW-1:0];
          open_q <= 1'b1;
          b8_q   <= (rx_byte == DW'(LOC_CTRL));
        end
      end

      if (wdat_vld) begin
        if (busy_all || !open_q) begin
          ack_q  <= 1'b0;
          open_q <= 1'b0;
        end else begin
          ack_q  <= dec.accept;
          ptr_q  <= ptr_nx;
          open_q <= b8_q & dec.accept & ~dec.to_nv;
          if (dec.to_ctrl) vol_q <= rx_byte[DW-1];
          if (dec.to_wiper) wiper_q <= rx_byte;
          if (dec.to_nv) begin
            pend_q   <= 1'b1;
            pend_idx <= ptr_q[IW-1:0];
            pend_dat <= rx_byte;
          end
        end
      end

      if (rd_req && !busy_all) begin
        rd_q  <= rd_mux;
        ptr_q <= ptr_nx;
      end
    end
  end

  assign ack     = ack_q;
  assign rd_data = rd_q;
  assign wiper   = wiper_q;
  assign busy    = busy_all;
endmodule

// File: rtl/dpot_regmap_chk.sv
module dpot_regmap_chk (
  input logic       clk,
  input logic       rst,
  input logic       wp_n,
  input logic       ev_stop,
  input logic       addr_vld,
  input logic       wdat_vld,
  input logic [7:0] rx_byte,
  input logic       ack,
  input logic [7:0] wiper,
  input logic       busy,
  input logic       prog_busy,
  input logic [3:0] ptr
);
  AST_RESET_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (wiper == 8'h80)); // R1
  AST_BAD_ADDR_NACK: assert property (@(posedge clk) disable iff (rst)
    (addr_vld && (rx_byte == 8'h07 || rx_byte > 8'h08)) |=> !ack); // R2
  AST_CTRL_ODD_NACK: assert property (@(posedge clk) disable iff (rst)
    (wdat_vld && !busy && ptr == 4'd8 && rx_byte != 8'h00 && rx_byte != 8'h80) |=> !ack); // R3
  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_busy) |-> $past(ev_stop)); // R7
  AST_BUSY_NACK: assert property (@(posedge clk) disable iff (rst)
    ((addr_vld || wdat_vld) && busy) |=> !ack); // R8
  AST_BUSY_WIPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wdat_vld && prog_busy) |=> $stable(wiper)); // R8
  AST_WP_GP_NACK: assert property (@(posedge clk) disable iff (rst)
    (wdat_vld && !wp_n && ptr >= 4'd2 && ptr <= 4'd6) |=> !ack); // R10
endmodule

bind dpot_regmap dpot_regmap_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wp_n      (wp_n),
  .ev_stop   (ev_stop),
  .addr_vld  (addr_vld),
  .wdat_vld  (wdat_vld),
  .rx_byte   (rx_byte),
  .ack       (ack),
  .wiper     (wiper),
  .busy      (busy),
  .prog_busy (nv_busy),
  .ptr       (ptr_q)
);

// File: tb/dpot_regmap_test.sv
module dpot_regmap_test;
  localparam int PROG = 40;
  localparam int RCL  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wp_n = 1'b1, ev_start = 1'b0, ev_stop = 1'b0, scl_rise = 1'b0;
  logic addr_vld = 1'b0, wdat_vld = 1'b0, rd_req = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic ack, busy;
  logic [7:0] rd_data, wiper;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  dpot_regmap #(.PROG_CYC(PROG), .RECALL_CYC(RCL)) uut (
    .clk(clk), .rst(rst), .wp_n(wp_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .scl_rise(scl_rise), .addr_vld(addr_vld), .wdat_vld(wdat_vld), .rd_req(rd_req),
    .rx_byte(rx_byte), .ack(ack), .rd_data(rd_data), .wiper(wiper), .busy(busy)
  );

  // Behavioural reference model
  int m_nv [7] = '{128, 0, 0, 0, 0, 0, 0};
  int m_wiper = 128, m_vol = 0, m_ptr = 0, m_ack = 0, m_rd = 0;
  bit m_open = 0, m_from8 = 0, m_stage = 0, m_rb = 1, m_pb = 0;
  int m_sidx = 0, m_sdat = 0, m_rc = RCL, m_pc = 0;

  function automatic int loc_read(int a);
    if (a == 0) return m_vol ? m_wiper : m_nv[0];
    if (a == 1) return 8'hD0;
    if (a >= 2 && a <= 6) return m_nv[a];
    if (a == 8) return m_vol ? 8'h80 : 8'h00;
    return 8'hFF;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_wiper = 128; m_vol = 0; m_ptr = 0; m_ack = 0; m_rd = 0;
      m_open = 0; m_from8 = 0; m_stage = 0; m_rb = 1; m_rc = RCL; m_pb = 0; m_pc = 0;
    end else begin
      automatic bit was_busy = m_rb || m_pb;
      automatic bit do_commit = ev_stop && m_stage && wp_n && !m_pb;
      automatic int p = m_ptr;
      automatic int nxt = (p == 8) ? 0 : p + 1;
      if (m_rb) begin
        if (m_rc == 1) begin m_rb = 0; m_wiper = m_nv[0]; end
        m_rc = m_rc - 1;
      end
      if (do_commit) begin
        m_nv[m_sidx] = m_sdat; m_pb = 1; m_pc = PROG;
      end else if (m_pb) begin
        if (m_pc == 1) m_pb = 0;
        m_pc = m_pc - 1;
      end
      if (ev_start || ev_stop || scl_rise || addr_vld || wdat_vld || rd_req) m_stage = 0;
      if (ev_start || ev_stop) m_open = 0;
      if (addr_vld) begin
        if (was_busy || rx_byte == 7 || rx_byte > 8) begin m_ack = 0; m_open = 0; end
        else begin m_ack = 1; m_ptr = rx_byte; m_open = 1; m_from8 = (rx_byte == 8); end
      end
      if (wdat_vld) begin
        if (was_busy || !m_open) begin m_ack = 0; m_open = 0; end
        else begin
          automatic bit ok = 0, nv = 0;
          if (p == 0) begin
            if (m_vol) begin ok = 1; m_wiper = rx_byte; end
            else if (wp_n) begin ok = 1; nv = 1; m_wiper = rx_byte; end
          end else if (p == 1) ok = 1;
          else if (p >= 2 && p <= 6) begin ok = wp_n; nv = wp_n; end
          else if (p == 8) begin
            m_vol = rx_byte[7];
            ok = (rx_byte == 8'h00 || rx_byte == 8'h80);
          end
          if (nv) begin m_stage = 1; m_sidx = p; m_sdat = rx_byte; end
          m_ack = ok; m_ptr = nxt; m_open = m_from8 && ok && !nv;
        end
      end
      if (rd_req && !was_busy) begin
        m_rd = loc_read(p); m_ptr = nxt;
      end
    end
  end

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model (R12 covers output timing)
  always @(negedge clk) begin
    if (!done && cyc > 0) begin
      check("R12 ack", ack, m_ack);
      check("R12 rd_data", rd_data, m_rd);
      check("R4 wiper", wiper, m_wiper);
      check("R8 busy", busy, m_rb || m_pb);
    end
  end

  task automatic report();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      report();
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic send_addr(logic [7:0] b);
    rx_byte = b; addr_vld = 1'b1; tick(); addr_vld = 1'b0; tick();
  endtask
  task automatic send_data(logic [7:0] b);
    rx_byte = b; wdat_vld = 1'b1; tick(); wdat_vld = 1'b0; tick();
  endtask
  task automatic read_byte();
    rd_req = 1'b1; tick(); rd_req = 1'b0; tick();
  endtask
  task automatic do_start();
    ev_start = 1'b1; tick(); ev_start = 1'b0; tick();
  endtask
  task automatic do_stop();
    ev_stop = 1'b1; tick(); ev_stop = 1'b0;
  endtask
  task automatic clock_bit();
    scl_rise = 1'b1; tick(); scl_rise = 1'b0; tick();
  endtask
  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; tick(); end
  endtask
  task automatic read_at(logic [7:0] a);
    do_start(); send_addr(a); do_start(); read_byte();
  endtask

  initial begin
    int n;
    tick(3);
    // R1: reset state and recall timing
    check("R1 wiper in reset", wiper, 8'h80);
    check("R1 busy in reset", busy, 1);
    rst = 1'b0;
    busy_len(n);
    check("R1 recall length", n, RCL);
    check("R6 IVR default recalled", wiper, 8'h80);
    // R2 address acceptance
    do_start(); send_addr(8'h07); check("R2 addr 07", ack, 0);
    send_addr(8'h0A); check("R2 addr 0A", ack, 0);
    send_addr(8'h06); check("R2 addr 06", ack, 1);
    do_stop(); tick();
    // R6 defaults, R5 ID
    read_at(8'h02); check("R6 GP default", rd_data, 8'h00);
    read_at(8'h01); check("R5 ID read", rd_data, 8'hD0);
    read_at(8'h00); check("R6 IVR default", rd_data, 8'h80);
    do_stop(); tick();
    do_start(); send_addr(8'h01); send_data(8'h55); check("R5 ID write ack", ack, 1);
    do_stop(); tick(2); check("R5 no commit", busy, 0);
    read_at(8'h01); check("R5 ID unchanged", rd_data, 8'hD0);
    do_stop(); tick();
    // R3 control flag
    do_start(); send_addr(8'h08); send_data(8'h81); check("R3 odd value NACK", ack, 0);
    do_stop(); tick();
    read_at(8'h08); check("R3 bit7 loaded", rd_data, 8'h80);
    do_stop(); tick();
    // R4 volatile path
    do_start(); send_addr(8'h00); send_data(8'h3C); check("R4 vol write ack", ack, 1);
    check("R4 wiper immediate", wiper, 8'h3C);
    do_stop(); tick(2); check("R4 volatile no busy", busy, 0);
    read_at(8'h00); check("R4 read wiper", rd_data, 8'h3C);
    do_stop(); tick();
    do_start(); send_addr(8'h08);
    // R12: ack keeps its old value in the event cycle
    rx_byte = 8'h00; wdat_vld = 1'b1; check("R12 ack before edge", ack, 1);
    tick(); wdat_vld = 1'b0; tick(); check("R3 00h ACK", ack, 1);
    do_stop(); tick();
    read_at(8'h00); check("R4 read IVR when flag 0", rd_data, 8'h80);
    do_stop(); tick();
    // R4/R8 non-volatile write of shared location
    do_start(); send_addr(8'h00); send_data(8'hA5);
    check("R4 wiper follows NV write", wiper, 8'hA5);
    do_stop(); check("R8 busy after stop", busy, 1);
    rx_byte = 8'h02; addr_vld = 1'b1; tick(); addr_vld = 1'b0; tick();
    check("R8 busy NACK", ack, 0);
    busy_len(n); check("R8 busy length", n, PROG - 2);
    read_at(8'h00); check("R4 IVR stored", rd_data, 8'hA5);
    do_stop(); tick();
    // R7 commit only on immediate STOP
    do_start(); send_addr(8'h03); send_data(8'h77); clock_bit(); do_stop(); tick();
    check("R7 SCL rise cancels", busy, 0);
    do_start(); send_addr(8'h04); send_data(8'h11); do_start(); do_stop(); tick();
    check("R7 START cancels", busy, 0);
    read_at(8'h03); check("R7 GP3 unchanged", rd_data, 8'h00);
    do_stop(); tick();
    do_start(); send_addr(8'h04); send_data(8'h22); do_stop();
    busy_len(n); check("R8 GP commit length", n, PROG);
    read_at(8'h04); check("R7 GP4 stored", rd_data, 8'h22);
    do_stop(); tick();
    // R9 bursts
    do_start(); send_addr(8'h08); send_data(8'h80); send_data(8'h12);
    check("R9 wrap 08h to 00h", wiper, 8'h12);
    send_data(8'h99); check("R9 ID in burst", ack, 1);
    send_data(8'h44); check("R9 GP in burst", ack, 1);
    send_data(8'h55); check("R9 after NV NACK", ack, 0);
    do_stop(); tick(2); check("R9 cancelled stage", busy, 0);
    do_start(); send_addr(8'h05); send_data(8'h01); send_data(8'h02);
    check("R9 non-08h burst NACK", ack, 0);
    do_stop(); tick(2); check("R9 cancelled stage 2", busy, 0);
    do_start(); send_addr(8'h08); send_data(8'h00); send_data(8'h6B); do_stop();
    busy_len(n); check("R9 burst commit", n, PROG);
    // R10 write protect
    wp_n = 1'b0;
    do_start(); send_addr(8'h05); send_data(8'h33); check("R10 GP NACK", ack, 0);
    do_stop(); tick();
    do_start(); send_addr(8'h00); send_data(8'h10); check("R10 IVR NACK", ack, 0);
    check("R10 wiper unchanged", wiper, 8'h6B);
    do_stop(); tick();
    wp_n = 1'b1;
    do_start(); send_addr(8'h06); send_data(8'h66); wp_n = 1'b0; do_stop(); tick();
    check("R10 protected stop", busy, 0);
    wp_n = 1'b1;
    read_at(8'h06); check("R10 GP6 unchanged", rd_data, 8'h00);
    do_stop(); tick();
    do_start(); send_addr(8'h06); send_data(8'h66); do_stop(); wp_n = 1'b0;
    busy_len(n); check("R10 late protect", n, PROG);
    wp_n = 1'b1;
    // R11 sequential reads
    read_at(8'h06); check("R11 GP6 stored", rd_data, 8'h66);
    read_byte(); check("R11 hole reads FFh", rd_data, 8'hFF);
    read_byte(); check("R11 ctrl", rd_data, 8'h00);
    read_byte(); check("R11 wrap to 0", rd_data, 8'h6B);
    do_stop(); tick(); do_start(); read_byte();
    check("R11 continue without address", rd_data, 8'hD0);
    do_stop(); tick();
    // R1 power cycle recalls stored value
    rst = 1'b1; tick(2);
    check("R1 midscale on reset", wiper, 8'h80);
    rst = 1'b0;
    busy_len(n); check("R1 recall length 2", n, RCL);
    check("R1 recalled IVR", wiper, 8'h6B);
    tick(4);
    report();
  end
endmodule